// File: doc/BRIEF.md
# SPI Device Word Engine

This block is the device-side front end of a SPI link. It shifts command and data words in on MOSI and out on MISO. How it shifts is set at run time by a small configuration byte that it holds itself. That byte selects 16-bit or 32-bit words, big-endian or little-endian byte order, and whether MISO changes on the same clock edge that samples MOSI or on the opposite one. A second register sets how many all-zero bytes the device sends between a read command and its data. This gives a slow host time for the read to complete.

A fixed identification word sits at one address. After power-up the host keeps reading that address until the expected pattern comes back, which tells it the device has left reset. Addresses that the engine does not hold itself are passed to an internal register port as one-cycle read or write strobes. The same configuration bits can also be written by an on-chip CPU through a separate byte port, except for the wake bit, which only the host can set.

The SPI pins are oversampled in the system clock domain, so every SPI edge becomes a single-cycle event inside the block.

Top module: `spi_wordeng`

## Requirements
- R1: After reset the configuration byte (address 0x00) reads 0x30: 16-bit words, little-endian, same-edge mode, interrupt polarity high, wake clear. The delay register (address 0x01) reads 0x04, and miso_o is 0.
- R2: Configuration bit 0 selects the word length, 0 for 16 bits and 1 for 32 bits. Both the command word and the data word use this length. In 16-bit mode, read data is the low 16 bits of the source.
- R3: Configuration bit 1 selects byte order, 1 for big-endian and 0 for little-endian. In little-endian mode the bytes of every word are reversed between the wire and the register port. Bits inside each byte always travel MSB first.
- R4: Configuration bit 4 selects the edge mode. With 1, MISO changes after the SCLK rising edge. With 0, MISO changes after the falling edge. In both modes the host samples on the rising edge and MOSI is sampled on the rising edge.
- R5: On a read, MISO carries exactly 8 × (delay register) zero bits after the last command bit and before the first data bit.
- R6: Reading address 0x14 returns ID_WORD. Writing address 0x14 changes nothing and produces no internal write strobe.
- R7: The host can write configuration bits 7, 5, 4, 1 and 0. The CPU port can write bits 5, 4, 1 and 0 but not bit 7. Both can write the delay register. wake_o follows bit 7 and irq_high_o follows bit 5.
- R8: Word length, byte order and edge mode are latched when chip-select falls. A change made during a transaction applies from the next transaction on.
- R9: If chip-select rises before the last bit of a data word, no register write and no internal write strobe take place.
- R10: The command word carries the write flag in its most significant bit and the address in bits [7:0]. For any other address, a completed write gives one bus_we_o pulse carrying that address and data, and a read gives one bus_re_o pulse whose bus_rdata_i becomes the read data.
- R11: MISO is 0 while chip-select is high, during the command word and after the last data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the SPI pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | SPI clock from host, idle low |
| cs_ni | input | 1 | SPI chip-select, active low |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial data to host |
| cpu_we_i | input | 1 | CPU configuration write strobe |
| cpu_addr_i | input | ADDR_W | CPU write address (0x00 or 0x01) |
| cpu_wdata_i | input | 8 | CPU write data |
| bus_addr_o | output | ADDR_W | Internal register port address |
| bus_wdata_o | output | 32 | Internal write data (decoded word) |
| bus_we_o | output | 1 | Internal write strobe, one cycle |
| bus_re_o | output | 1 | Internal read strobe, one cycle |
| bus_rdata_i | input | 32 | Internal read data, valid while bus_re_o is high |
| wake_o | output | 1 | Wake request (configuration bit 7) |
| irq_high_o | output | 1 | Interrupt polarity (configuration bit 5) |

## Verification
Reads and writes are run in all four combinations of word length and byte order. The data words are chosen so that every byte is different, which means a missing or partial byte swap shows up as a wrong value. Read delays of 0, 2 and 4 bytes confirm that the zero gap before the data changes with the register setting and is not fixed. MISO is also sampled in the middle of each high phase, in both edge modes. A stream whose bits alternate shows whether MISO moved at the rising edge or waited for the falling one. Finally, writes that are cut off early and CPU writes made in the middle of a transaction check that aborts leave the registers untouched and that new settings are deferred until the next chip-select.

// File: rtl/spi_wordeng_pkg.sv
package spi_wordeng_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned BYTE_W = 8;

  localparam logic [7:0] CFG_RST   = 8'h30;
  localparam logic [7:0] HOST_MASK = 8'hB3;
  localparam logic [7:0] CPU_MASK  = 8'h33;

  typedef enum logic [2:0] {
    PH_IDLE, PH_CMD, PH_WDATA, PH_PAD, PH_RDATA, PH_END
  } phase_e;

  typedef struct packed {
    logic same_edge;
    logic big_end;
    logic w32;
  } xcfg_t;

  function automatic xcfg_t unpack_cfg(input logic [7:0] b);
    xcfg_t c;
    c.same_edge = b[4];
    c.big_end   = b[1];
    c.w32       = b[0];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] fit_word(input logic [WORD_W-1:0] w, input logic w32);
    return w32 ? w : {16'h0, w[15:0]};
  endfunction

  function automatic logic [WORD_W-1:0] swap_bytes(input logic [WORD_W-1:0] w, input logic w32);
    return w32 ? {w[7:0], w[15:8], w[23:16], w[31:24]} : {16'h0, w[7:0], w[15:8]};
  endfunction
endpackage

// File: rtl/spi_wordeng_sync.sv
module spi_wordeng_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_wordeng_cfg.sv
module spi_wordeng_cfg
  import spi_wordeng_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter logic [7:0]  DLY_RST = 8'h04
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [7:0]        host_wdata_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [7:0]        cpu_wdata_i,
  output logic [7:0]        cfg_byte_o,
  output logic [7:0]        dly_o
);
  localparam int unsigned NREG = 2;
  localparam logic [7:0] RSTV [NREG] = '{CFG_RST, DLY_RST};
  localparam logic [7:0] HMSK [NREG] = '{HOST_MASK, 8'hFF};
  localparam logic [7:0] CMSK [NREG] = '{CPU_MASK, 8'hFF};

  logic [7:0] reg_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic host_hit, cpu_hit;
    assign host_hit = host_we_i && (host_addr_i == ADDR_W'(g));
    assign cpu_hit  = cpu_we_i  && (cpu_addr_i  == ADDR_W'(g));
    // host wins a same-cycle collision
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)       reg_q[g] <= RSTV[g];
      else if (host_hit) reg_q[g] <= (reg_q[g] & ~HMSK[g]) | (host_wdata_i & HMSK[g]);
      else if (cpu_hit)  reg_q[g] <= (reg_q[g] & ~CMSK[g]) | (cpu_wdata_i & CMSK[g]);
  end

  assign cfg_byte_o = reg_q[0];
  assign dly_o      = reg_q[1];
endmodule

// File: rtl/spi_wordeng_xfer.sv
module spi_wordeng_xfer
  import spi_wordeng_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DLY_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_low_i,
  input  logic              cs_fall_i,
  input  logic              sclk_rise_i,
  input  logic              sclk_fall_i,
  input  logic              mosi_i,
  input  xcfg_t             cfg_i,
  input  logic [DLY_W-1:0]  dly_i,
  input  logic [WORD_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [WORD_W-1:0] wdata_o,
  output logic              wr_o,
  output logic              rd_o,
  output logic              miso_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W) + 1;
  localparam int unsigned PAD_W = DLY_W + 3;

  phase_e              phase_q;
  xcfg_t               act_q;
  logic [CNT_W-1:0]    bit_q;
  logic [PAD_W-1:0]    pad_q;
  logic [WORD_W-2:0]   rx_q;
  logic [WORD_W-1:0]   tx_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [WORD_W-1:0]   wdata_q;
  logic                wr_q, rd_q, nxt_q, miso_q;
  logic                rise_d1_q, rise_d2_q;

  logic [CNT_W-1:0]  wlast, wlen;
  logic [WORD_W-1:0] raw, fitted, dec, rv_fit, rv_ord, tx_load;
  logic              cmd_wr;

  assign wlast  = act_q.w32 ? CNT_W'(31) : CNT_W'(15);
  assign wlen   = act_q.w32 ? CNT_W'(32) : CNT_W'(16);
  assign raw    = {rx_q, mosi_i};
  assign fitted = fit_word(raw, act_q.w32);
  assign dec    = act_q.big_end ? fitted : swap_bytes(fitted, act_q.w32);
  assign cmd_wr = act_q.w32 ? dec[31] : dec[15];

  assign rv_fit  = fit_word(rdata_i, act_q.w32);
  assign rv_ord  = act_q.big_end ? rv_fit : swap_bytes(rv_fit, act_q.w32);
  // left-align so the MSB always sits at the top of the shifter
  assign tx_load = act_q.w32 ? rv_ord : {rv_ord[15:0], 16'h0};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      act_q     <= unpack_cfg(CFG_RST);
      bit_q     <= '0;
      pad_q     <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      wr_q      <= 1'b0;
      rd_q      <= 1'b0;
      nxt_q     <= 1'b0;
      miso_q    <= 1'b0;
      rise_d1_q <= 1'b0;
      rise_d2_q <= 1'b0;
    end else begin
      wr_q      <= 1'b0;
      rd_q      <= 1'b0;
      rise_d1_q <= sclk_rise_i && cs_low_i;
      rise_d2_q <= rise_d1_q;
      if (!cs_low_i) begin
        phase_q <= PH_IDLE;
        nxt_q   <= 1'b0;
        miso_q  <= 1'b0;
      end else if (cs_fall_i) begin
        act_q   <= cfg_i;
        phase_q <= PH_CMD;
        bit_q   <= '0;
        nxt_q   <= 1'b0;
        miso_q  <= 1'b0;
      end else begin
        if (sclk_rise_i) begin
          rx_q <= raw[WORD_W-2:0];
          unique case (phase_q)
            PH_CMD: begin
              nxt_q <= 1'b0;
              if (bit_q == wlast) begin
                addr_q <= dec[ADDR_W-1:0];
                bit_q  <= '0;
                if (cmd_wr) begin
                  phase_q <= PH_WDATA;
                end else begin
                  rd_q <= 1'b1;
                  if (dly_i == '0) phase_q <= PH_RDATA;
                  else begin
                    phase_q <= PH_PAD;
                    pad_q   <= {dly_i, 3'b000} - PAD_W'(1);
                  end
                end
              end else begin
                bit_q <= bit_q + CNT_W'(1);
              end
            end
            PH_WDATA: begin
              if (bit_q == wlast) begin
                wdata_q <= dec;
                wr_q    <= 1'b1;
                phase_q <= PH_END;
              end else begin
                bit_q <= bit_q + CNT_W'(1);
              end
            end
            PH_PAD: begin
              if (pad_q == '0) begin
                nxt_q   <= tx_q[WORD_W-1];
                tx_q    <= tx_q << 1;
                bit_q   <= CNT_W'(1);
                phase_q <= PH_RDATA;
              end else begin
                nxt_q <= 1'b0;
                pad_q <= pad_q - PAD_W'(1);
              end
            end
            PH_RDATA: begin
              if (bit_q == wlen) begin
                nxt_q   <= 1'b0;
                phase_q <= PH_END;
              end else begin
                nxt_q <= tx_q[WORD_W-1];
                tx_q  <= tx_q << 1;
                bit_q <= bit_q + CNT_W'(1);
              end
            end
            default: nxt_q <= 1'b0;
          endcase
        end else if (rd_q) begin
          // read data arrives one cycle after the command word closes
          if (phase_q == PH_RDATA) begin
            nxt_q <= tx_load[WORD_W-1];
            tx_q  <= tx_load << 1;
            bit_q <= CNT_W'(1);
          end else begin
            tx_q <= tx_load;
          end
        end
        if (act_q.same_edge ? rise_d2_q : sclk_fall_i) miso_q <= nxt_q;
      end
    end
  end

  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
  assign wr_o    = wr_q;
  assign rd_o    = rd_q;
  assign miso_o  = miso_q;
endmodule

// File: rtl/spi_wordeng.sv
module spi_wordeng
  import spi_wordeng_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [7:0]  DLY_RST     = 8'h04,
  parameter logic [ADDR_W-1:0] ID_ADDR = 8'h14,
  parameter logic [31:0] ID_WORD     = 32'h5EED_C0DE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              mosi_i,
  output logic              miso_o,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [7:0]        cpu_wdata_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [31:0]       bus_wdata_o,
  output logic              bus_we_o,
  output logic              bus_re_o,
  input  logic [31:0]       bus_rdata_i,
  output logic              wake_o,
  output logic              irq_high_o
);
  localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DLY = ADDR_W'(1);

  logic              sclk_s, cs_s, mosi_s, sclk_d_q, cs_d_q;
  logic              sclk_rise, sclk_fall, cs_fall;
  logic [7:0]        cfg_byte, dly;
  logic [ADDR_W-1:0] x_addr;
  logic [WORD_W-1:0] x_wdata, rdata_mux;
  logic              x_wr, x_rd, is_local, host_cfg_wr;

  spi_wordeng_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_i, cs_ni, mosi_i}),
    .q_o   ({sclk_s, cs_s, mosi_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      sclk_d_q <= 1'b0;
      cs_d_q   <= 1'b1;
    end else begin
      sclk_d_q <= sclk_s;
      cs_d_q   <= cs_s;
    end

  assign sclk_rise = sclk_s & ~sclk_d_q;
  assign sclk_fall = ~sclk_s & sclk_d_q;
  assign cs_fall   = ~cs_s & cs_d_q;

  spi_wordeng_cfg #(.ADDR_W(ADDR_W), .DLY_RST(DLY_RST)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .host_we_i   (x_wr),
    .host_addr_i (x_addr),
    .host_wdata_i(x_wdata[7:0]),
    .cpu_we_i    (cpu_we_i),
    .cpu_addr_i  (cpu_addr_i),
    .cpu_wdata_i (cpu_wdata_i),
    .cfg_byte_o  (cfg_byte),
    .dly_o       (dly)
  );

  always_comb begin
    unique case (x_addr)
      A_CFG:   rdata_mux = {24'h0, cfg_byte};
      A_DLY:   rdata_mux = {24'h0, dly};
      ID_ADDR: rdata_mux = ID_WORD;
      default: rdata_mux = bus_rdata_i;
    endcase
  end

  spi_wordeng_xfer #(.ADDR_W(ADDR_W), .DLY_W(8)) u_xfer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_low_i   (~cs_s),
    .cs_fall_i  (cs_fall),
    .sclk_rise_i(sclk_rise),
    .sclk_fall_i(sclk_fall),
    .mosi_i     (mosi_s),
    .cfg_i      (unpack_cfg(cfg_byte)),
    .dly_i      (dly),
    .rdata_i    (rdata_mux),
    .addr_o     (x_addr),
    .wdata_o    (x_wdata),
    .wr_o       (x_wr),
    .rd_o       (x_rd),
    .miso_o     (miso_o)
  );

  assign is_local    = (x_addr == A_CFG) || (x_addr == A_DLY) || (x_addr == ID_ADDR);
  assign host_cfg_wr = x_wr && (x_addr == A_CFG);
  assign bus_addr_o  = x_addr;
  assign bus_wdata_o = x_wdata;
  assign bus_we_o    = x_wr && !is_local;
  assign bus_re_o    = x_rd && !is_local;
  assign wake_o      = cfg_byte[7];
  assign irq_high_o  = cfg_byte[5];
endmodule

// File: rtl/spi_wordeng_chk.sv
module spi_wordeng_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_s,
  input logic miso_o,
  input logic bus_we_o,
  input logic bus_re_o,
  input logic wake_o,
  input logic host_wr
);
  AST_RD_WR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_we_o && bus_re_o)); // R10
  AST_WE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_o |=> !bus_we_o); // R10
  AST_MISO_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_s && $past(cs_s)) |-> !miso_o); // R11
  AST_WAKE_HOST_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wake_o) |-> $past(host_wr)); // R7
  AST_WR_NEEDS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_o |-> !$past(cs_s)); // R9
endmodule

bind spi_wordeng spi_wordeng_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_s    (cs_s),
  .miso_o  (miso_o),
  .bus_we_o(bus_we_o),
  .bus_re_o(bus_re_o),
  .wake_o  (wake_o),
  .host_wr (host_cfg_wr)
);

// File: tb/spi_wordeng_tb.sv
module spi_wordeng_tb;
  localparam int H = 8;
  localparam logic [31:0] ID = 32'h5EED_C0DE;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic cpu_we = 1'b0;
  logic [7:0] cpu_addr = '0, cpu_wdata = '0;
  logic miso, bus_we, bus_re, wake, irq_high;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  assign bus_rdata = {8'hC3, bus_addr, ~bus_addr, 8'h5A};

  spi_wordeng u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata), .bus_we_o(bus_we),
    .bus_re_o(bus_re), .bus_rdata_i(bus_rdata), .wake_o(wake), .irq_high_o(irq_high)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] m_cfg = 8'h30, m_dly = 8'h04;
  int exp_we = 0, we_cnt = 0;
  logic [7:0]  we_addr;
  logic [31:0] we_data;

  always @(posedge clk) if (bus_we) begin
    we_cnt++; we_addr = bus_addr; we_data = bus_wdata;
  end

  function automatic logic [31:0] sw(input logic [31:0] v, input bit w32);
    return w32 ? {v[7:0], v[15:8], v[23:16], v[31:24]} : {16'h0, v[7:0], v[15:8]};
  endfunction
  function automatic logic [31:0] fit(input logic [31:0] v, input bit w32);
    return w32 ? v : {16'h0, v[15:0]};
  endfunction
  function automatic logic [31:0] exp_read(input logic [7:0] a, input bit w32);
    logic [31:0] v;
    case (a)
      8'h00:   v = {24'h0, m_cfg};
      8'h01:   v = {24'h0, m_dly};
      8'h14:   v = ID;
      default: v = {8'hC3, a, ~a, 8'h5A};
    endcase
    return fit(v, w32);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic [7:0] a, input logic [7:0] v);
    @(negedge clk); cpu_we = 1'b1; cpu_addr = a; cpu_wdata = v;
    @(negedge clk); cpu_we = 1'b0;
    if (a == 8'h00) m_cfg = (m_cfg & ~8'h33) | (v & 8'h33);
    else if (a == 8'h01) m_dly = v;
  endtask

  task automatic xfer(input bit wr, input logic [7:0] a, input logic [31:0] d,
                      input int cut, input bit mid, input logic [7:0] mv, input string tag);
    bit w32, be, same;
    int W, P, N;
    logic [31:0] cmd, ce, de, rv;
    bit hb[$];
    bit ex[$];
    w32 = m_cfg[0]; be = m_cfg[1]; same = m_cfg[4];
    W = w32 ? 32 : 16;
    P = wr ? 0 : int'(m_dly) * 8;
    cmd = fit(({31'b0, wr} << (W - 1)) | {24'h0, a}, w32);
    ce  = be ? cmd : sw(cmd, w32);
    de  = be ? fit(d, w32) : sw(fit(d, w32), w32);
    rv  = exp_read(a, w32);
    rv  = be ? rv : sw(rv, w32);
    for (int i = W - 1; i >= 0; i--) hb.push_back(ce[i]);
    if (wr) for (int i = W - 1; i >= 0; i--) hb.push_back(de[i]);
    else    for (int i = 0; i < P + W; i++) hb.push_back(1'b0);
    ex.push_back(1'b0);
    for (int k = 0; k < W + P; k++) ex.push_back(1'b0);
    for (int i = W - 1; i >= 0; i--) ex.push_back(wr ? 1'b0 : rv[i]);
    ex.push_back(1'b0);
    N = (cut >= 0) ? W + cut : hb.size();
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int k = 1; k <= N; k++) begin
      mosi = hb[k-1];
      repeat (H) @(negedge clk);
      check((k <= W) ? "R11" : ((k <= W + P) ? "R5" : tag), {31'b0, miso}, {31'b0, ex[k]});
      sclk = 1'b1;
      if (mid && k == W + 2) begin
        cpu_wr(8'h00, mv);
        repeat (H - 3) @(negedge clk);
      end else begin
        repeat (H - 1) @(negedge clk);
      end
      check("R4", {31'b0, miso}, {31'b0, same ? ex[k+1] : ex[k]});
      @(negedge clk); sclk = 1'b0;
    end
    repeat (H) @(negedge clk);
    cs_n = 1'b1; mosi = 1'b0;
    repeat (2 * H) @(negedge clk);
    check("R11", {31'b0, miso}, 32'h0);
    if (wr && cut < 0) begin
      if (a == 8'h00)      m_cfg = (m_cfg & ~8'hB3) | (d[7:0] & 8'hB3);
      else if (a == 8'h01) m_dly = d[7:0];
      else if (a != 8'h14) begin
        exp_we++;
        check("R10", {24'h0, we_addr}, {24'h0, a});
        check(tag, we_data, fit(d, w32));
      end
    end
    check((cut >= 0) ? "R9" : "R10", we_cnt, exp_we);
    check("R7", {30'b0, wake, irq_high}, {30'b0, m_cfg[7], m_cfg[5]});
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", {29'b0, miso, wake, irq_high}, 32'h1);
    xfer(0, 8'h00, 0, -1, 0, 0, "R1");
    xfer(0, 8'h01, 0, -1, 0, 0, "R1");
    xfer(0, 8'h14, 0, -1, 0, 0, "R6");
    xfer(1, 8'h40, 32'h1234, -1, 0, 0, "R3");
    xfer(0, 8'h55, 0, -1, 0, 0, "R10");
    xfer(1, 8'h01, 32'h0, -1, 0, 0, "R5");
    xfer(0, 8'h14, 0, -1, 0, 0, "R5");
    xfer(1, 8'h00, 32'h33, -1, 0, 0, "R7");
    xfer(0, 8'h14, 0, -1, 0, 0, "R2");
    xfer(0, 8'h00, 0, -1, 0, 0, "R7");
    xfer(1, 8'h41, 32'hA1B2_C3D4, -1, 0, 0, "R2");
    xfer(1, 8'h00, 32'h21, -1, 0, 0, "R7");
    xfer(0, 8'h14, 0, -1, 0, 0, "R4");
    xfer(0, 8'h56, 0, -1, 0, 0, "R3");
    xfer(1, 8'h42, 32'h0102_0304, -1, 0, 0, "R3");
    xfer(1, 8'h14, 32'hFFFF_FFFF, -1, 0, 0, "R6");
    xfer(0, 8'h14, 0, -1, 0, 0, "R6");
    xfer(1, 8'h43, 32'h7777_8888, 10, 0, 0, "R9");
    xfer(1, 8'h00, 32'h33, 5, 0, 0, "R9");
    xfer(0, 8'h00, 0, -1, 0, 0, "R9");
    cpu_wr(8'h00, 8'hB0);
    check("R7", {31'b0, wake}, 32'h0);
    cpu_wr(8'h01, 8'h02);
    xfer(0, 8'h01, 0, -1, 0, 0, "R5");
    xfer(1, 8'h00, 32'hB0, -1, 0, 0, "R7");
    xfer(0, 8'h14, 0, -1, 1, 8'h33, "R8");
    xfer(0, 8'h14, 0, -1, 0, 0, "R8");
    cpu_wr(8'h00, 8'h13);
    repeat (2) @(negedge clk);
    check("R7", {30'b0, wake, irq_high}, 32'h2);
    done = 1;
    summary();
    $finish;
  end
endmodule